// File: doc/BRIEF.md
# Four-Word Burst Dual-Port SRAM

This block is an on-chip memory with a read port and a write port that work independently but share one address bus. Every address selects a group of four data words, and every access moves the whole group as a fixed burst: two words per clock over two clocks on either port. This models a double-data-rate link inside a single-edge design. Writes carry an active-low byte mask for every word, so a burst can update any subset of bytes in the group.

A read starts when `rd_sel_n` is low. The address on the bus in that cycle is the read address. A write starts when `wr_sel_n` is low. The first two words and their masks are taken in that cycle. The write address and the last two words follow on the next cycle, which plays the role of the late half of the clock. Read data comes back two cycles after the request, with `rd_vld` high for both data cycles. A read that loads its first two words on the same edge at which a write to the same group commits returns the newly written bytes.

The read controller has three states. `RD_IDLE` goes to `RD_HEAD` on an accepted select. `RD_HEAD` always goes to `RD_TAIL`, and the edge that leaves it loads words 0 and 1. `RD_TAIL` loads words 2 and 3, then goes to `RD_HEAD` if a new select is accepted and to `RD_IDLE` if not. The write controller has two states. `WR_IDLE` goes to `WR_TAIL` on an accepted select and holds the first half of the burst. `WR_TAIL` always returns to `WR_IDLE`, and that edge commits the merged group to the array.

Top module: `burst4_sram`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `rd_vld` is low and both controllers are idle, so a select in the first cycle after reset is accepted.
- R2: A write select in cycle T takes words 0 and 1 from `wr_d_a`/`wr_d_b`. In cycle T+1 the bus carries the group address and the same pins carry words 2 and 3. The group is stored at the end of T+1.
- R3: A read select in cycle T with address A puts words 0 and 1 of A on `rd_q_a`/`rd_q_b` in cycle T+2, and words 2 and 3 in cycle T+3. `rd_vld` is high in exactly those two cycles.
- R4: Mask bit i of a word is active low and covers bits [8i+7:8i]. A mask bit that is high leaves that byte of the stored word unchanged.
- R5: A cycle in which neither select is low changes no stored data and starts no read data.
- R6: A read select in the cycle after an accepted read is ignored. A write select in the cycle after an accepted write is ignored, and its data is never stored.
- R7: Read selects every second cycle produce an unbroken `rd_vld` stream, four words per request, in request order.
- R8: A read selected in the same cycle as a write to the same group returns the bytes that write stores, merged with the old bytes where the mask is high.
- R9: When a read select and a write select are low in the same cycle, that cycle's address is the read address and the next cycle's address is the write address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Shared group address (read in select cycle, write one cycle later) |
| rd_sel_n | input | 1 | Active-low read request |
| wr_sel_n | input | 1 | Active-low write request |
| wr_d_a | input | WORD_W | Earlier write word of the cycle (word 0, then word 2) |
| wr_d_b | input | WORD_W | Later write word of the cycle (word 1, then word 3) |
| wr_bw_n_a | input | WORD_W/8 | Active-low byte mask for `wr_d_a` |
| wr_bw_n_b | input | WORD_W/8 | Active-low byte mask for `wr_d_b` |
| rd_q_a | output | WORD_W | Earlier read word of the cycle (word 0, then word 2) |
| rd_q_b | output | WORD_W | Later read word of the cycle (word 1, then word 3) |
| rd_vld | output | 1 | High while `rd_q_a`/`rd_q_b` carry burst data |

## Verification
If the read controller entered a wrong state, `rd_vld` would show it within one or two cycles: a burst of one or three cycles, a missing burst, or words 2 and 3 appearing before words 0 and 1. If the write controller lost its place, a later burst would read back a stale or shifted group: the first half paired with the wrong address, or a busy-cycle write that was stored. This shows up on the first read of the affected group, which is why every group is read back soon after it is written. A forwarding fault appears only in the cycle where a read and a write to the same group coincide, so that case is driven on purpose as well as at random.

// File: rtl/burst4_pkg.sv
package burst4_pkg;

    localparam int unsigned GROUP_WORDS   = 4;
    localparam int unsigned WORDS_PER_CLK = 2;

    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_HEAD = 2'd1,
        RD_TAIL = 2'd2
    } rd_state_e;

    typedef enum logic {
        WR_IDLE = 1'b0,
        WR_TAIL = 1'b1
    } wr_state_e;

endpackage

// File: rtl/burst4_rd_ctrl.sv
module burst4_rd_ctrl
    import burst4_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_sel_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              load_head,
    output logic              load_tail
);

    rd_state_e state, nxt;
    logic      accept;

    // next-state decision
    always_comb begin
        accept = !rd_sel_n && (state == RD_IDLE || state == RD_TAIL);
        nxt    = state;
        unique case (state)
            RD_IDLE: if (accept) nxt = RD_HEAD;
            RD_HEAD: nxt = RD_TAIL;
            RD_TAIL: nxt = accept ? RD_HEAD : RD_IDLE;
            default: nxt = RD_IDLE;
        endcase
    end

    // state register and captured address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= RD_IDLE;
            rd_addr <= '0;
        end else begin
            state <= nxt;
            if (accept) rd_addr <= addr;
        end
    end

    // outputs
    always_comb begin
        load_head = (state == RD_HEAD);
        load_tail = (state == RD_TAIL);
    end

endmodule

// File: rtl/burst4_wr_ctrl.sv
module burst4_wr_ctrl
    import burst4_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int BE_W   = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_sel_n,
    input  logic [WORD_W-1:0]             d_a,
    input  logic [WORD_W-1:0]             d_b,
    input  logic [BE_W-1:0]               bw_n_a,
    input  logic [BE_W-1:0]               bw_n_b,
    output logic                          commit,
    output logic [WORDS_PER_CLK*WORD_W-1:0] head_data,
    output logic [WORDS_PER_CLK*BE_W-1:0]   head_mask_n
);

    wr_state_e state, nxt;
    logic      accept;

    always_comb begin
        accept = !wr_sel_n && (state == WR_IDLE);
        nxt    = state;
        unique case (state)
            WR_IDLE: if (accept) nxt = WR_TAIL;
            WR_TAIL: nxt = WR_IDLE;
            default: nxt = WR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= WR_IDLE;
            head_data   <= '0;
            head_mask_n <= '1;
        end else begin
            state <= nxt;
            if (accept) begin
                head_data   <= {d_b, d_a};
                head_mask_n <= {bw_n_b, bw_n_a};
            end
        end
    end

    always_comb begin
        commit = (state == WR_TAIL);
    end

endmodule

// File: rtl/burst4_array.sv
module burst4_array
    import burst4_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8,
    parameter int BE_W   = WORD_W / BYTE_W
) (
    input  logic                          clk,
    input  logic                          we,
    input  logic [ADDR_W-1:0]             waddr,
    input  logic [GROUP_WORDS*WORD_W-1:0] wdata,
    input  logic [GROUP_WORDS*BE_W-1:0]   wmask_n,
    input  logic [ADDR_W-1:0]             raddr,
    output logic [GROUP_WORDS*WORD_W-1:0] rgroup
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int GRP_W = GROUP_WORDS * WORD_W;

    logic [GRP_W-1:0] mem [DEPTH];
    logic [GRP_W-1:0] old_g;
    logic [GRP_W-1:0] new_g;

    assign old_g = mem[waddr];

    // byte-wise merge of incoming group over stored group
    for (genvar w = 0; w < GROUP_WORDS; w++) begin : g_word
        for (genvar b = 0; b < BE_W; b++) begin : g_byte
            localparam int LSB = w * WORD_W + b * BYTE_W;
            assign new_g[LSB +: BYTE_W] = wmask_n[w * BE_W + b] ?
                                          old_g[LSB +: BYTE_W] :
                                          wdata[LSB +: BYTE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= new_g;
    end

    // write-through: a commit on this edge is visible to a load on this edge
    assign rgroup = (we && waddr == raddr) ? new_g : mem[raddr];

endmodule

// File: rtl/burst4_sram.sv
module burst4_sram
    import burst4_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8,
    localparam int BE_W  = WORD_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_sel_n,
    input  logic              wr_sel_n,
    input  logic [WORD_W-1:0] wr_d_a,
    input  logic [WORD_W-1:0] wr_d_b,
    input  logic [BE_W-1:0]   wr_bw_n_a,
    input  logic [BE_W-1:0]   wr_bw_n_b,
    output logic [WORD_W-1:0] rd_q_a,
    output logic [WORD_W-1:0] rd_q_b,
    output logic              rd_vld
);

    localparam int GRP_W = GROUP_WORDS * WORD_W;

    logic [ADDR_W-1:0]               rd_addr;
    logic                            load_head;
    logic                            load_tail;
    logic                            wr_tail;
    logic [WORDS_PER_CLK*WORD_W-1:0] head_data;
    logic [WORDS_PER_CLK*BE_W-1:0]   head_mask_n;
    logic [GRP_W-1:0]                rgroup;

    burst4_rd_ctrl #(.ADDR_W(ADDR_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_sel_n  (rd_sel_n),
        .addr      (addr),
        .rd_addr   (rd_addr),
        .load_head (load_head),
        .load_tail (load_tail)
    );

    burst4_wr_ctrl #(.WORD_W(WORD_W), .BE_W(BE_W)) u_wr (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_sel_n    (wr_sel_n),
        .d_a         (wr_d_a),
        .d_b         (wr_d_b),
        .bw_n_a      (wr_bw_n_a),
        .bw_n_b      (wr_bw_n_b),
        .commit      (wr_tail),
        .head_data   (head_data),
        .head_mask_n (head_mask_n)
    );

    burst4_array #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W),
        .BYTE_W (BYTE_W),
        .BE_W   (BE_W)
    ) u_arr (
        .clk     (clk),
        .we      (wr_tail),
        .waddr   (addr),
        .wdata   ({wr_d_b, wr_d_a, head_data}),
        .wmask_n ({wr_bw_n_b, wr_bw_n_a, head_mask_n}),
        .raddr   (rd_addr),
        .rgroup  (rgroup)
    );

    // read output register: head words, then tail words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_vld <= 1'b0;
            rd_q_a <= '0;
            rd_q_b <= '0;
        end else begin
            rd_vld <= load_head || load_tail;
            if (load_head) begin
                rd_q_a <= rgroup[0 * WORD_W +: WORD_W];
                rd_q_b <= rgroup[1 * WORD_W +: WORD_W];
            end else if (load_tail) begin
                rd_q_a <= rgroup[2 * WORD_W +: WORD_W];
                rd_q_b <= rgroup[3 * WORD_W +: WORD_W];
            end
        end
    end

endmodule

// File: rtl/burst4_sram_chk.sv
module burst4_sram_chk (
    input logic clk,
    input logic rst_n,
    input logic rd_sel_n,
    input logic wr_sel_n,
    input logic rd_vld,
    input logic wr_tail
);

    AST_RESET_CLEARS_VLD: assert property (@(posedge clk)
        !rst_n |=> !rd_vld); // R1

    AST_WR_TAIL_FROM_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_tail) |-> $past(!wr_sel_n)); // R2

    AST_VLD_PAIRS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_vld) |=> rd_vld); // R3

    AST_VLD_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld |-> (!$past(rd_sel_n, 2) || !$past(rd_sel_n, 3))); // R5

    AST_WR_TAIL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tail |=> !wr_tail); // R6

    AST_VLD_EVEN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_vld) |-> $past(rd_vld, 2)); // R7

endmodule

bind burst4_sram burst4_sram_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_sel_n (rd_sel_n),
    .wr_sel_n (wr_sel_n),
    .rd_vld   (rd_vld),
    .wr_tail  (wr_tail)
);

// File: tb/burst4_sram_tb.sv
module burst4_sram_tb;

    localparam int ADDR_W = 6;
    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;
    localparam int BE_W   = WORD_W / BYTE_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              rd_sel_n = 1'b1;
    logic              wr_sel_n = 1'b1;
    logic [WORD_W-1:0] wr_d_a = '0;
    logic [WORD_W-1:0] wr_d_b = '0;
    logic [BE_W-1:0]   wr_bw_n_a = '1;
    logic [BE_W-1:0]   wr_bw_n_b = '1;
    logic [WORD_W-1:0] rd_q_a;
    logic [WORD_W-1:0] rd_q_b;
    logic              rd_vld;

    always #4 clk = ~clk;

    burst4_sram #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .rd_sel_n  (rd_sel_n),
        .wr_sel_n  (wr_sel_n),
        .wr_d_a    (wr_d_a),
        .wr_d_b    (wr_d_b),
        .wr_bw_n_a (wr_bw_n_a),
        .wr_bw_n_b (wr_bw_n_b),
        .rd_q_a    (rd_q_a),
        .rd_q_b    (rd_q_b),
        .rd_vld    (rd_vld)
    );

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [WORD_W-1:0] marr [DEPTH][4];
    int                w_phase = 0;
    int                r_stage = 0;
    int                r_addr  = 0;
    logic [WORD_W-1:0] w_hd [2];
    logic [BE_W-1:0]   w_hm [2];
    logic              exp_vld = 1'b0;
    logic [WORD_W-1:0] exp_a = '0;
    logic [WORD_W-1:0] exp_b = '0;

    task automatic put_word(input int a, input int k, input logic [WORD_W-1:0] d,
                            input logic [BE_W-1:0] m);
        for (int b = 0; b < BE_W; b++)
            if (!m[b]) marr[a][k][b*BYTE_W +: BYTE_W] = d[b*BYTE_W +: BYTE_W];
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            w_phase = 0;
            r_stage = 0;
            exp_vld = 1'b0;
        end else begin
            // write side: commit first so same-edge reads see new bytes
            if (w_phase == 1) begin
                put_word(int'(addr), 0, w_hd[0], w_hm[0]);
                put_word(int'(addr), 1, w_hd[1], w_hm[1]);
                put_word(int'(addr), 2, wr_d_a, wr_bw_n_a);
                put_word(int'(addr), 3, wr_d_b, wr_bw_n_b);
                w_phase = 0;
            end else if (!wr_sel_n) begin
                w_hd[0] = wr_d_a; w_hd[1] = wr_d_b;
                w_hm[0] = wr_bw_n_a; w_hm[1] = wr_bw_n_b;
                w_phase = 1;
            end
            // read side
            exp_vld = 1'b0;
            if (r_stage == 1) begin
                exp_a = marr[r_addr][0]; exp_b = marr[r_addr][1];
                exp_vld = 1'b1; r_stage = 2;
            end else if (r_stage == 2) begin
                exp_a = marr[r_addr][2]; exp_b = marr[r_addr][3];
                exp_vld = 1'b1; r_stage = 0;
            end
            if (r_stage == 0 && !rd_sel_n) begin
                r_addr  = int'(addr);
                r_stage = 1;
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        chk(rd_vld === exp_vld, "rd_vld", longint'(rd_vld), longint'(exp_vld));
        if (exp_vld) begin
            chk(rd_q_a === exp_a, "rd_q_a", longint'(rd_q_a), longint'(exp_a));
            chk(rd_q_b === exp_b, "rd_q_b", longint'(rd_q_b), longint'(exp_b));
        end
    end

    // ---------------- stimulus ----------------
    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            rd_sel_n = 1'b1;
            wr_sel_n = 1'b1;
        end
    endtask

    task automatic slot(input bit rd, input bit wr, input int ra, input int wa,
                        input logic [4*WORD_W-1:0] dg, input logic [4*BE_W-1:0] mg,
                        input bit busy_rd, input bit busy_wr);
        @(negedge clk);
        addr      = ADDR_W'(ra);
        rd_sel_n  = !rd;
        wr_sel_n  = !wr;
        wr_d_a    = dg[0*WORD_W +: WORD_W];
        wr_d_b    = dg[1*WORD_W +: WORD_W];
        wr_bw_n_a = mg[0*BE_W +: BE_W];
        wr_bw_n_b = mg[1*BE_W +: BE_W];
        @(negedge clk);
        addr      = ADDR_W'(wa);
        rd_sel_n  = !(rd && busy_rd);
        wr_sel_n  = !(wr && busy_wr);
        wr_d_a    = dg[2*WORD_W +: WORD_W];
        wr_d_b    = dg[3*WORD_W +: WORD_W];
        wr_bw_n_a = mg[2*BE_W +: BE_W];
        wr_bw_n_b = mg[3*BE_W +: BE_W];
    endtask

    function automatic logic [4*WORD_W-1:0] rnd_data();
        return {$urandom, $urandom};
    endfunction

    function automatic logic [4*BE_W-1:0] rnd_mask();
        return (4*BE_W)'($urandom);
    endfunction

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (3) @(negedge clk);
        chk(rd_vld === 1'b0, "rd_vld during reset", longint'(rd_vld), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rd_vld === 1'b0, "rd_vld after reset", longint'(rd_vld), 0);

        // R2: fill every group with full writes
        cur_req = "R2";
        for (int a = 0; a < DEPTH; a++) slot(0, 1, 0, a, rnd_data(), '0, 0, 0);
        for (int a = 0; a < 8; a++) slot(1, 0, a, 0, '0, '1, 0, 0);
        idle(4);

        // R3: isolated reads with gaps
        cur_req = "R3";
        for (int i = 0; i < 10; i++) begin
            slot(1, 0, $urandom_range(0, DEPTH-1), 0, '0, '1, 0, 0);
            idle(3);
        end

        // R4: partial writes with random masks, then read back
        cur_req = "R4";
        for (int i = 0; i < 40; i++)
            slot(0, 1, 0, $urandom_range(0, 7), rnd_data(), rnd_mask(), 0, 0);
        for (int a = 0; a < 8; a++) slot(1, 0, a, 0, '0, '1, 0, 0);
        idle(4);

        // R5: no select, active data and masks on the pins
        cur_req = "R5";
        for (int i = 0; i < 8; i++) slot(0, 0, i, i, rnd_data(), '0, 0, 0);
        for (int a = 0; a < 8; a++) slot(1, 0, a, 0, '0, '1, 0, 0);
        idle(4);

        // R6: selects in the busy cycle are ignored
        cur_req = "R6";
        for (int i = 0; i < 10; i++)
            slot(1, 1, $urandom_range(0, 7), $urandom_range(8, 15), rnd_data(), rnd_mask(), 1, 1);
        idle(4);
        for (int a = 8; a < 16; a++) slot(1, 0, a, 0, '0, '1, 0, 0);
        idle(4);

        // R7: back-to-back reads every second cycle
        cur_req = "R7";
        for (int i = 0; i < 16; i++) slot(1, 0, i, 0, '0, '1, 0, 0);
        idle(4);

        // R8: read and write to the same group in one slot
        cur_req = "R8";
        for (int i = 0; i < 12; i++) begin
            int a = $urandom_range(0, 7);
            slot(1, 1, a, a, rnd_data(), rnd_mask(), 0, 0);
        end
        idle(4);

        // R9: random mix of simultaneous reads and writes
        cur_req = "R9";
        for (int i = 0; i < 300; i++)
            slot($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
                 $urandom_range(0, 15), $urandom_range(0, 15),
                 rnd_data(), rnd_mask(),
                 $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0);
        idle(6);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule